// File: doc/BRIEF.md
# Reloading Interval Timer

The block is a 16-bit interval timer that counts upward. A free-running divider lets the count step once every four clocks. When a step would carry the count from all ones to zero, the count takes the value held in a 16-bit reload register. The same rollover raises a sticky timeout flag, and the flag also drives the interrupt output. Software sets the period by writing the reload register one byte at a time. It can sample the running count one byte at a time, and a snapshot makes the two bytes agree.

The register ports are byte wide, with a one-bit byte select. On the write side, select 0 addresses the low byte of the reload value and select 1 addresses the high byte. On the read side, select 0 returns the live low byte of the count and select 1 returns the high byte that was captured by the last low-byte read. Clock generation and address decoding are handled outside the block.

Top module: `ivt_timer`

## Requirements
- R1: The count changes only on every fourth rising clock edge after reset is released, and the first change comes on the fourth edge.
- R2: On a stepping edge where the count is not 16'hFFFF, the count increases by exactly one.
- R3: On a stepping edge where the count is 16'hFFFF, the count takes the reload value as it stood before that edge, not zero. A reload value of 16'hFFFF therefore makes every step a rollover.
- R4: A rollover sets timeout_flag at that same edge, and irq is high whenever timeout_flag is high.
- R5: Once set, timeout_flag stays high until flag_clr is sampled high at an edge with no rollover. It is low after that edge.
- R6: When flag_clr is high at the same edge as a rollover, the set wins and timeout_flag stays high.
- R7: A write with wr_en high and wr_sel 0 loads wr_data into bits 7:0 of the reload value, and wr_sel 1 loads bits 15:8. A write changes only the reload value and leaves the running count untouched until the next rollover.
- R8: With rd_sel 0, rd_data shows bits 7:0 of the live count. An edge with rd_en high and rd_sel 0 copies count bits 15:8 into a holding byte, and rd_sel 1 shows that holding byte even after the count has moved on.
- R9: While reset is low, the count is CNT_INIT (default 0), the reload value is 0, timeout_flag and irq are low, and the holding byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the reload value |
| wr_sel | input | 1 | Byte select for writes: 0 low, 1 high |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe; with rd_sel 0 it captures the high count byte |
| rd_sel | input | 1 | Byte select for reads: 0 live low, 1 held high |
| rd_data | output | 8 | Selected read byte (combinational) |
| flag_clr | input | 1 | Clears the timeout flag |
| timeout_flag | output | 1 | Sticky rollover flag |
| irq | output | 1 | Interrupt request, follows the flag |

## Verification
The count, the reload value, the flag and the holding byte are each one register away from their inputs. Rollover, reload and flag set therefore all become visible together, one edge after the stepping edge. A write, a clear or a snapshot appears one edge after the strobe, and rd_data follows rd_sel in the same cycle without a register. The bench drives every input at the falling edge and reads one unit after it, counting edges from each rollover it detects. In that way the reload value, the unchanged count three edges later, the increment on the fourth edge and the held high byte are each checked in the single cycle where they are due.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int CNT_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int NUM_LANES = CNT_W / BYTE_W;
  localparam int LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  typedef logic [CNT_W-1:0]  count_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [LANE_W-1:0] lane_t;

  // terminal value: every bit set
  function automatic logic is_terminal(input count_t c);
    return &c;
  endfunction

  // value after one step: reload at terminal, else one more
  function automatic count_t step_value(input count_t c, input count_t reload);
    return is_terminal(c) ? reload : c + count_t'(1);
  endfunction

  function automatic byte_t lane_of(input count_t v, input lane_t idx);
    return v[idx*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick = (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= '0;
    else if (tick) phase_q <= '0;
    else           phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/ivt_reload_reg.sv
module ivt_reload_reg
  import ivt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  lane_t  wr_lane,
  input  byte_t  wr_byte,
  output count_t reload_q
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    byte_t part_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                part_q <= '0;
      else if (wr_en && wr_lane == lane_t'(g))   part_q <= wr_byte;
    end
    assign reload_q[g*BYTE_W +: BYTE_W] = part_q;
  end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
  import ivt_pkg::*;
#(
  parameter count_t CNT_INIT = '0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  count_t reload,
  output count_t count_q,
  output logic   roll
);
  assign roll = tick && is_terminal(count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= CNT_INIT;
    else if (tick) count_q <= step_value(count_q, reload);
  end
endmodule

// File: rtl/ivt_status.sv
module ivt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag_q
);
  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_ev) flag_q <= 1'b1;
    else if (clr_ev) flag_q <= 1'b0;
  end
endmodule

// File: rtl/ivt_readback.sv
module ivt_readback
  import ivt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rd_en,
  input  lane_t  rd_lane,
  input  count_t count,
  output byte_t  rd_byte
);
  byte_t view [NUM_LANES];
  logic  snap;

  // reading the low lane freezes the upper lanes
  assign snap    = rd_en && (rd_lane == lane_t'(0));
  assign view[0] = lane_of(count, lane_t'(0));

  for (genvar g = 1; g < NUM_LANES; g++) begin : g_hold
    byte_t hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hold_q <= '0;
      else if (snap) hold_q <= lane_of(count, lane_t'(g));
    end
    assign view[g] = hold_q;
  end

  assign rd_byte = view[rd_lane];
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int     PRE_DIV  = 4,
  parameter count_t CNT_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [LANE_W-1:0] rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              flag_clr,
  output logic              timeout_flag,
  output logic              irq
);
  logic   tick;
  logic   roll;
  count_t count_q;
  count_t latch_q;

  ivt_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  ivt_reload_reg u_reload (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_lane (wr_sel),
    .wr_byte (wr_data),
    .reload_q(latch_q)
  );

  ivt_counter #(.CNT_INIT(CNT_INIT)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .reload (latch_q),
    .count_q(count_q),
    .roll   (roll)
  );

  ivt_status u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set_ev(roll),
    .clr_ev(flag_clr),
    .flag_q(timeout_flag)
  );

  ivt_readback u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .rd_lane(rd_sel),
    .count  (count_q),
    .rd_byte(rd_data)
  );

  assign irq = timeout_flag;
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk
  import ivt_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   tick,
  input logic   roll,
  input count_t count_q,
  input count_t latch_q,
  input logic   timeout_flag,
  input logic   flag_clr,
  input logic   irq
);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_q));

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !roll) |=> (count_q == $past(count_q) + count_t'(1)));

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> (count_q == $past(latch_q)));

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> timeout_flag);

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(roll));

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !flag_clr) |=> timeout_flag);

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !roll) |=> !timeout_flag);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && roll) |=> timeout_flag);
endmodule

bind ivt_timer ivt_timer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .roll        (roll),
  .count_q     (count_q),
  .latch_q     (latch_q),
  .timeout_flag(timeout_flag),
  .flag_clr    (flag_clr),
  .irq         (irq)
);

// File: tb/ivt_timer_test.sv
module ivt_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [0:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [0:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       flag_clr = 1'b0;
  logic       timeout_flag;
  logic       irq;

  int errors = 0;
  int checks = 0;

  // {reload value, count expected one step after the reload}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {16'hFFF0, 16'hFFF1},
    {16'hFF80, 16'hFF81},
    {16'hFEFF, 16'hFF00},
    {16'hFE01, 16'hFE02},
    {16'hFFFE, 16'hFFFF},
    {16'hFFFF, 16'hFFFF}
  };

  always #4 clk = ~clk;

  ivt_timer #(.PRE_DIV(4), .CNT_INIT(16'hFFC0)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .flag_clr    (flag_clr),
    .timeout_flag(timeout_flag),
    .irq         (irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic sel, output logic [7:0] val);
    rd_sel = sel;
    #1;
    val = rd_data;
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] lat;
    logic [15:0] nxt;
    logic [15:0] prev_nxt;
    int          waited;
    prev_nxt = '0;

    repeat (3) @(negedge clk);
    // R9: reset values, seen before the first edge after release
    peek(1'b0, b); check("R9 count low", {8'h0, b}, 16'h00C0);
    peek(1'b1, b); check("R9 held high", {8'h0, b}, 16'h0000);
    check("R9 flag", {15'h0, timeout_flag}, 16'h0);
    check("R9 irq", {15'h0, irq}, 16'h0);
    rst_n = 1'b1;

    // R1: first step on the fourth edge after release
    repeat (3) @(negedge clk);
    peek(1'b0, b); check("R1 no step before edge 4", {8'h0, b}, 16'h00C0);
    @(negedge clk);
    peek(1'b0, b); check("R1 step at edge 4", {8'h0, b}, 16'h00C1);

    for (int i = 0; i < NV; i++) begin
      lat = VEC[i][31:16];
      nxt = VEC[i][15:0];
      // R7: write the reload value, low byte then high byte
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = lat[7:0];
      @(negedge clk);
      wr_sel = 1'b1; wr_data = lat[15:8];
      @(negedge clk);
      wr_en = 1'b0; flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      if (i > 0) begin
        // R7: writing the reload value left the count as it was
        peek(1'b0, b); check("R7 count undisturbed", {8'h0, b}, {8'h0, prev_nxt[7:0]});
      end
      waited = 0;
      do begin
        @(negedge clk);
        waited++;
      end while (!timeout_flag && waited < 20000);
      // R4: flag and irq rise with the rollover
      check("R4 flag set", {15'h0, timeout_flag}, 16'h1);
      check("R4 irq", {15'h0, irq}, 16'h1);
      // R3: count reloaded from the reload value
      rd_en = 1'b1;
      peek(1'b0, b); check("R3 reload low", {8'h0, b}, {8'h0, lat[7:0]});
      @(negedge clk);
      rd_en = 1'b0;
      peek(1'b1, b); check("R3 reload high", {8'h0, b}, {8'h0, lat[15:8]});
      @(negedge clk);
      // R5: still set without a clear
      check("R5 sticky", {15'h0, timeout_flag}, 16'h1);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      check("R5 cleared", {15'h0, timeout_flag}, 16'h0);
      check("R5 irq cleared", {15'h0, irq}, 16'h0);
      // R1: three edges after reload, no step yet
      rd_en = 1'b1;
      peek(1'b0, b); check("R1 no early step", {8'h0, b}, {8'h0, lat[7:0]});
      @(negedge clk);
      rd_en = 1'b0;
      // R8: held high byte predates the step
      peek(1'b1, b); check("R8 held high", {8'h0, b}, {8'h0, lat[15:8]});
      // R2: step at the fourth edge (R3 when the reload is all ones)
      peek(1'b0, b); check("R2 step low", {8'h0, b}, {8'h0, nxt[7:0]});
      prev_nxt = nxt;
    end

    // R6: the reload is all ones, so every step rolls over; clear at a rollover edge
    repeat (3) @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    check("R6 set wins over clear", {15'h0, timeout_flag}, 16'h1);
    @(negedge clk);
    flag_clr = 1'b0;
    check("R5 clear off rollover", {15'h0, timeout_flag}, 16'h0);

    finish_run();
  end
endmodule